// File: doc/BRIEF.md
# SHA-1 Iterative Compression Engine

This block performs the SHA-1 compression function on one 512-bit message block that has already been padded. The block arrives as sixteen 32-bit words written through a word-load port while the engine is idle. A 160-bit chaining value is presented on a parallel input. A start pulse copies that chaining value into the working registers. The engine then runs the 80 compression steps at one step per clock. A final cycle adds the working registers to the saved chaining value. The result appears on a registered 160-bit output, and a one-cycle done pulse marks it.

The message schedule is not kept as 80 words. The engine holds a sliding window of sixteen words. On every step it consumes the oldest word and appends the next expanded word. The round function and the additive constant are chosen from the step number. Padding, memory traffic and multi-block sequencing are left to the surrounding logic. To hash a longer message, that logic feeds each result back in as the next chaining value.

Top module: `sha1_step_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `chainOut` is all zeros.
- R2: A `startReq` sampled while idle raises `busy` on the next cycle. `busy` then stays high for exactly 81 cycles: 80 step cycles and one final-addition cycle. `busy` and `done` are never high together.
- R3: `done` is high for exactly one cycle. That cycle is the first cycle after `busy` falls. `chainOut` takes its new value on the same edge that raises `done`.
- R4: `chainOut` equals the SHA-1 compression of the loaded block under the chaining value sampled at start. The packing is H0 in bits 159:128, then H1, H2 and H3, with H4 in bits 31:0. For the padded empty message (word 0 = 80000000h, words 1..15 = 0) under the standard initial value 67452301 efcdab89 98badcfe 10325476 c3d2e1f0, the result is da39a3ee 5e6b4b0d 3255bfef 95601890 afd80709.
- R5: Words 0..15 of the schedule are the loaded words, with word index 0 used first. Each later word t is rotl1(W[t-3] xor W[t-8] xor W[t-14] xor W[t-16]).
- R6: Steps 0-19 use the choose function with constant 5a827999h. Steps 20-39 use parity with 6ed9eba1h. Steps 40-59 use majority with 8f1bbcdch. Steps 60-79 use parity with ca62c1d6h.
- R7: Each step computes T = rotl5(A) + F(B,C,D) + W + K + E modulo 2^32. It then shifts (A,B,C,D,E) to (T, A, rotl30(B), C, D). After the last step, each output word is the saved input word plus the matching working register, modulo 2^32.
- R8: A `startReq` while `busy` is high is ignored. The run in progress keeps its length and its result.
- R9: `wordLoadEn` while `busy` is high is ignored. It changes neither the running result nor the window.
- R10: `chainOut` holds its value in every cycle except the one in which `done` rises.
- R11: A result fed back as the chaining value of a following block gives the chained two-block compression.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse, accepted only when idle |
| wordLoadEn | input | 1 | Write enable for one block word, accepted only when idle |
| wordLoadIdx | input | 4 | Index (0..15) of the block word being written |
| wordLoadData | input | 32 | Block word value |
| chainIn | input | 160 | Chaining value sampled at start, H0 in the top bits |
| busy | output | 1 | High from the cycle after start through the final-addition cycle |
| done | output | 1 | One-cycle pulse marking a new result |
| chainOut | output | 160 | Updated chaining value, H0 in the top bits |

## Verification
The bench aims at the step boundaries where the round function and constant change. A design that switched at 19, 39 or 59 would give a wrong digest for both the empty-message vector and random blocks. Window indexing is the second target. A tap off by one, or a shift in the wrong direction, gives a correct digest only while no expanded word is used, so random blocks expose it. The bench also pulses start and word loads in the middle of a run. A design that restarted, or wrote into the window while busy, would lengthen the busy period or corrupt the result. The per-cycle model also catches a `done` that lasts two cycles or comes one cycle early or late.

// File: rtl/sha1_eng_pkg.sv
package sha1_eng_pkg;
  localparam int WORD_W    = 32;
  localparam int WIN_WORDS = 16;
  localparam int NUM_STEPS = 80;
  localparam int ROUND_LEN = 20;
  localparam int LANES     = 5;
  localparam int CHAIN_W   = WORD_W * LANES;
  localparam int STEP_W    = $clog2(NUM_STEPS);
  localparam int IDX_W     = $clog2(WIN_WORDS);

  typedef logic [WORD_W-1:0] word_t;

  // strobes issued by the sequencer to the datapath
  typedef struct packed {
    logic acceptLoad;  // block words may be written
    logic loadWork;    // copy chaining value into working regs
    logic stepEn;      // perform one compression step
    logic finalAdd;    // fold working regs into saved chain
  } ctrlStrobes_t;

  function automatic word_t rotl(input word_t v, input int n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction
endpackage

// File: rtl/sha1_eng_ctrl.sv
module sha1_eng_ctrl
  import sha1_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  output ctrlStrobes_t      strb,
  output logic [STEP_W-1:0] stepIdx,
  output logic              busy,
  output logic              done
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FOLD} engState_t;

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  engState_t stateQ;
  logic [STEP_W-1:0] stepCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (stateQ)
        ST_IDLE: if (startReq) begin
          stateQ  <= ST_RUN;
          stepCnt <= '0;
        end
        ST_RUN: begin
          if (stepCnt == LAST_STEP) stateQ <= ST_FOLD;
          else stepCnt <= stepCnt + 1'b1;
        end
        ST_FOLD: begin
          stateQ <= ST_IDLE;
          done   <= 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.acceptLoad = (stateQ == ST_IDLE);
    strb.loadWork   = (stateQ == ST_IDLE) && startReq;
    strb.stepEn     = (stateQ == ST_RUN);
    strb.finalAdd   = (stateQ == ST_FOLD);
  end

  assign stepIdx = stepCnt;
  assign busy    = (stateQ != ST_IDLE);
endmodule

// File: rtl/sha1_eng_datapath.sv
module sha1_eng_datapath
  import sha1_eng_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [STEP_W-1:0]  stepIdx,
  input  logic               wordLoadEn,
  input  logic [IDX_W-1:0]   wordLoadIdx,
  input  word_t              wordLoadData,
  input  logic [CHAIN_W-1:0] chainIn,
  output logic [CHAIN_W-1:0] chainOut
);
  localparam logic [31:0] K_CHOOSE = 32'h5a827999;
  localparam logic [31:0] K_PAR_LO = 32'h6ed9eba1;
  localparam logic [31:0] K_MAJ    = 32'h8f1bbcdc;
  localparam logic [31:0] K_PAR_HI = 32'hca62c1d6;

  word_t win [WIN_WORDS];
  word_t work [LANES];
  word_t saved [LANES];
  word_t fOut, kSel, tSum, mixW, nextW;
  logic [1:0] roundSel;

  // round number from step range
  always_comb begin
    if (int'(stepIdx) < ROUND_LEN)          roundSel = 2'd0;
    else if (int'(stepIdx) < 2 * ROUND_LEN) roundSel = 2'd1;
    else if (int'(stepIdx) < 3 * ROUND_LEN) roundSel = 2'd2;
    else                                    roundSel = 2'd3;
  end

  always_comb begin
    case (roundSel)
      2'd0: begin
        fOut = (work[1] & work[2]) | (~work[1] & work[3]);
        kSel = K_CHOOSE;
      end
      2'd1: begin
        fOut = work[1] ^ work[2] ^ work[3];
        kSel = K_PAR_LO;
      end
      2'd2: begin
        fOut = (work[1] & work[2]) | (work[1] & work[3]) | (work[2] & work[3]);
        kSel = K_MAJ;
      end
      default: begin
        fOut = work[1] ^ work[2] ^ work[3];
        kSel = K_PAR_HI;
      end
    endcase
    tSum  = rotl(work[0], 5) + fOut + win[0] + kSel + work[4];
    mixW  = win[13] ^ win[8] ^ win[2] ^ win[0];
    nextW = rotl(mixW, 1);
  end

  // sliding schedule window: slot 0 holds the word for the current step
  for (genvar i = 0; i < WIN_WORDS; i++) begin : g_win
    word_t shiftIn;
    if (i == WIN_WORDS - 1) begin : g_tail
      assign shiftIn = nextW;
    end else begin : g_body
      assign shiftIn = win[i+1];
    end
    always_ff @(posedge clk) begin
      if (!rstN) win[i] <= '0;
      else if (strb.stepEn) win[i] <= shiftIn;
      else if (strb.acceptLoad && wordLoadEn && (wordLoadIdx == IDX_W'(i)))
        win[i] <= wordLoadData;
    end
  end

  // working registers and saved chaining value, lane 0 = H0 at the top
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int HI = CHAIN_W - 1 - l * WORD_W;
    word_t stepNext;
    if (l == 0) begin : g_a
      assign stepNext = tSum;
    end else if (l == 2) begin : g_c
      assign stepNext = rotl(work[1], 30);
    end else begin : g_pass
      assign stepNext = work[l-1];
    end
    always_ff @(posedge clk) begin
      if (!rstN) begin
        work[l]  <= '0;
        saved[l] <= '0;
        chainOut[HI -: WORD_W] <= '0;
      end else begin
        if (strb.loadWork) begin
          work[l]  <= chainIn[HI -: WORD_W];
          saved[l] <= chainIn[HI -: WORD_W];
        end else if (strb.stepEn) begin
          work[l] <= stepNext;
        end
        if (strb.finalAdd) chainOut[HI -: WORD_W] <= saved[l] + work[l];
      end
    end
  end
endmodule

// File: rtl/sha1_step_engine.sv
module sha1_step_engine
  import sha1_eng_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               wordLoadEn,
  input  logic [3:0]         wordLoadIdx,
  input  logic [31:0]        wordLoadData,
  input  logic [159:0]       chainIn,
  output logic               busy,
  output logic               done,
  output logic [159:0]       chainOut
);
  ctrlStrobes_t      strb;
  logic [STEP_W-1:0] stepIdx;

  sha1_eng_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .strb     (strb),
    .stepIdx  (stepIdx),
    .busy     (busy),
    .done     (done)
  );

  sha1_eng_datapath u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .stepIdx      (stepIdx),
    .wordLoadEn   (wordLoadEn),
    .wordLoadIdx  (wordLoadIdx),
    .wordLoadData (wordLoadData),
    .chainIn      (chainIn),
    .chainOut     (chainOut)
  );
endmodule

// File: rtl/sha1_engine_chk.sv
module sha1_engine_chk
  import sha1_eng_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic         startReq,
  input logic         busy,
  input logic         done,
  input logic [159:0] chainOut
);
  localparam int RUN_CYCLES = NUM_STEPS + 1;
  int busyLen;

  always_ff @(posedge clk) begin
    if (!rstN) busyLen <= 0;
    else if (busy) busyLen <= busyLen + 1;
    else busyLen <= 0;
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq) |=> busy);

  // R2
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R8
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == RUN_CYCLES));

  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  chain_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(chainOut));
endmodule

bind sha1_step_engine sha1_engine_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .startReq (startReq),
  .busy     (busy),
  .done     (done),
  .chainOut (chainOut)
);

// File: tb/tb_sha1_step_engine.sv
`timescale 1ns/1ps
module tb_sha1_step_engine;
  logic         clk = 1'b0;
  logic         rstN;
  logic         startReq;
  logic         wordLoadEn;
  logic [3:0]   wordLoadIdx;
  logic [31:0]  wordLoadData;
  logic [159:0] chainIn;
  logic         busy, done;
  logic [159:0] chainOut;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit timedOut = 0;

  always #2.5 clk = ~clk;

  sha1_step_engine dut (.*);

  localparam logic [159:0] IV =
    160'h67452301_efcdab89_98badcfe_10325476_c3d2e1f0;

  // ---------------- behavioural reference ----------------
  logic [31:0]  mWords [16];
  bit           mBusy, mDone;
  int           mCnt;
  logic [159:0] mChain, mPending;

  function automatic logic [31:0] rl(input logic [31:0] v, input int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic logic [159:0] refCompress(input logic [159:0] h,
                                               input logic [31:0] blk [16]);
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, t;
    for (int i = 0; i < 16; i++) w[i] = blk[i];
    for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
    {a, b, c, d, e} = h;
    for (int i = 0; i < 80; i++) begin
      if (i < 20)      begin f = (b & c) ^ (~b & d);            k = 32'h5a827999; end
      else if (i < 40) begin f = b ^ c ^ d;                     k = 32'h6ed9eba1; end
      else if (i < 60) begin f = (b & c) ^ (b & d) ^ (c & d);   k = 32'h8f1bbcdc; end
      else             begin f = b ^ c ^ d;                     k = 32'hca62c1d6; end
      t = rl(a, 5) + f + w[i] + k + e;
      e = d; d = c; c = rl(b, 30); b = a; a = t;
    end
    return {h[159:128] + a, h[127:96] + b, h[95:64] + c, h[63:32] + d, h[31:0] + e};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mCnt = 0; mChain = '0;
      for (int i = 0; i < 16; i++) mWords[i] = '0;
    end else begin
      mDone = 0;
      if (!mBusy) begin
        if (wordLoadEn) mWords[wordLoadIdx] = wordLoadData;
        if (startReq) begin
          mPending = refCompress(chainIn, mWords);
          mBusy = 1; mCnt = 0;
        end
      end else begin
        mCnt++;
        if (mCnt == 81) begin
          mBusy = 0; mDone = 1; mChain = mPending;
          // R5: window is consumed by the run; model forgets the block
          for (int i = 0; i < 16; i++) mWords[i] = 'x;
        end
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      checks += 3;
      if (busy !== mBusy) begin
        failures++; $display("FAIL R2 busy cycle %0d: got %0b exp %0b", cycles, busy, mBusy);
      end
      if (done !== mDone) begin
        failures++; $display("FAIL R3 done cycle %0d: got %0b exp %0b", cycles, done, mDone);
      end
      if (chainOut !== mChain) begin
        failures++; $display("FAIL R4 chainOut cycle %0d: got %h exp %h", cycles, chainOut, mChain);
      end
    end
  end

  task automatic check(input string req, input logic [159:0] got, input logic [159:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  task automatic loadWord(input int idx, input logic [31:0] val);
    @(negedge clk);
    wordLoadEn = 1; wordLoadIdx = 4'(idx); wordLoadData = val;
    @(negedge clk);
    wordLoadEn = 0;
  endtask

  task automatic startRun(input logic [159:0] h);
    @(negedge clk);
    chainIn = h; startReq = 1;
    @(negedge clk);
    startReq = 0;
  endtask

  task automatic waitDone();
    while (!done && !timedOut) @(negedge clk);
  endtask

  logic [159:0] firstOut;
  logic [31:0]  blkA [16];
  logic [31:0]  blkB [16];

  initial begin
    rstN = 0; startReq = 0; wordLoadEn = 0; wordLoadIdx = 0; wordLoadData = 0;
    chainIn = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", {159'b0, busy}, 160'b0);
    check("R1 done", {159'b0, done}, 160'b0);
    check("R1 chainOut", chainOut, 160'b0);
    rstN = 1;

    // R4 R6 R7: padded empty message
    loadWord(0, 32'h80000000);
    for (int i = 1; i < 16; i++) loadWord(i, 32'h0);
    startRun(IV);
    check("R2 busy after start", {159'b0, busy}, {159'b0, 1'b1});
    waitDone();
    check("R4 empty digest", chainOut,
          160'hda39a3ee_5e6b4b0d_3255bfef_95601890_afd80709);
    @(negedge clk);
    check("R3 done single cycle", {159'b0, done}, 160'b0);

    // R5 R8 R9: random block, random chain, interference mid-run
    for (int i = 0; i < 16; i++) begin
      blkA[i] = $urandom; loadWord(i, blkA[i]);
    end
    startRun({$urandom, $urandom, $urandom, $urandom, $urandom});
    repeat (10) @(negedge clk);
    startReq = 1;                                   // R8 start while busy
    @(negedge clk); startReq = 0;
    repeat (20) @(negedge clk);
    wordLoadEn = 1; wordLoadIdx = 4'd3; wordLoadData = 32'hdeadbeef;  // R9
    @(negedge clk); wordLoadEn = 0;
    waitDone();
    firstOut = chainOut;
    check("R5 R8 R9 digest matches model", chainOut, mChain);

    // R10 result holds while idle, loads do not touch it
    loadWord(7, 32'h12345678);
    repeat (5) @(negedge clk);
    check("R10 chainOut held", chainOut, firstOut);

    // R11 chained block using previous result
    for (int i = 0; i < 16; i++) begin
      blkB[i] = $urandom; loadWord(i, blkB[i]);
    end
    startRun(firstOut);
    waitDone();
    check("R11 chained digest", chainOut, refCompress(firstOut, blkB));

    // R6 boundary stress: block of all ones, chain of zeros
    for (int i = 0; i < 16; i++) loadWord(i, 32'hffffffff);
    startRun(160'h0);
    waitDone();
    check("R6 R7 all-ones block", chainOut, mChain);
    repeat (3) @(negedge clk);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    timedOut = 1;
    failures++;
    checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule